// File: doc/BRIEF.md
# Virtual Instruction Cache Fetch Aligner

This block is the front of an instruction fetch path. It holds a prefetch program counter and looks it up in a small, virtually addressed instruction cache. Each cache line is 32 bytes, split into four 8-byte quadwords. A line carries a tag, a block-valid flag and one valid flag per quadword. The lookup takes one cycle.

On a hit, the addressed quadword is rotated by the low three PC bits. The byte the PC points at is the first byte appended to a 25-byte instruction buffer, and the decoder reads that buffer from byte 0. The prefetch PC then moves to the next quadword boundary. An instruction that runs past the end of a line is therefore completed by a second lookup on the following cycle.

The decoder removes bytes from the front of the buffer with a consume count. The execution side can restart fetch at any 32-bit address with a redirect. Missing quadwords are requested through a miss address and written back one quadword at a time through a refill port.

Top module: `ifetch_vcache`

## Requirements
- R1: After reset the instruction buffer is empty (all `ibuf_valid` bits 0), the prefetch PC is `RESET_PC` (default 0), and `miss_req` is 1 because every line is invalid.
- R2: A lookup hits only when all three conditions hold: the line's block-valid flag is set, its stored tag equals PC bits 31:13, and the valid flag of the quadword selected by PC bits 4:3 is set. The line is chosen by PC bits 12:5.
- R3: Without a hit, `miss_req` is 1 and `miss_addr` is the PC with bits 2:0 cleared; no bytes are appended on that cycle.
- R4: On a hit, the quadword bytes from byte PC[2:0] through byte 7 are appended behind the bytes the buffer keeps (at buffer byte 0 when it is empty). Byte k of a quadword is data bits 8k+7:8k. Buffer byte 0 is `ibuf_data[7:0]`, and the count grows by 8 - PC[2:0]; the result is visible after the clock edge.
- R5: After an append, the prefetch PC becomes the next 8-byte boundary, so a run past a line end performs a second lookup on the next line one cycle later.
- R6: On each edge, `consume_cnt` bytes are removed from the front of the buffer, clamped to the number held, and the remaining bytes move down to byte 0.
- R7: An append happens only if 25 minus the bytes kept after consumption is at least 8 - PC[2:0]. Otherwise fetch stalls with the PC and the buffer tail unchanged.
- R8: A redirect empties the buffer and loads the PC from `redir_pc` at the next edge; nothing is appended on that cycle.
- R9: A refill writes one quadword, addressed by `refill_addr` (PC bits 31:3), and sets its valid flag. If the line is valid with the same tag, its other quadword flags are kept; otherwise the tag is replaced and the other three flags are cleared.
- R10: `ibuf_valid` is a thermometer code: bit i is 1 exactly when the buffer holds more than i bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Restart fetch at `redir_pc` |
| redir_pc | input | 32 | Restart address |
| refill_valid | input | 1 | Write one quadword into the cache |
| refill_addr | input | 29 | Quadword address (PC bits 31:3) |
| refill_data | input | 64 | Quadword data, byte k in bits 8k+7:8k |
| consume_cnt | input | 5 | Bytes taken by the decoder this cycle |
| ibuf_data | output | 200 | Instruction buffer, byte i in bits 8i+7:8i |
| ibuf_valid | output | 25 | Per-byte valid flags |
| miss_req | output | 1 | Current lookup misses |
| miss_addr | output | 32 | Quadword-aligned address of the missing fetch |

## Verification
A corrupted quadword-valid flag or tag shows up on the cycle after the lookup, as a wrong `miss_req` or as bytes that should not have been appended. A wrong rotation or shift count appears in `ibuf_data` right after the edge that appended or consumed. An off-by-one buffer count changes the `ibuf_valid` thermometer at once, and changes the stall point a few cycles later when the buffer nears 25 bytes. The bench runs a reference model in step with the design every cycle, so any such divergence is reported on the first edge where it becomes visible.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ifetch_tagstore.sv
module ifetch_tagstore #(
  parameter int unsigned TAG_W  = 19,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned QSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [QSEL_W-1:0] lk_qsel,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [QSEL_W-1:0] wr_qsel,
  output logic              lk_hit
);
  localparam int unsigned NLINES = 1 << IDX_W;
  localparam int unsigned LQ     = 1 << QSEL_W;

  logic [TAG_W-1:0]  tag_q    [NLINES];
  logic [LQ-1:0]     qw_vld_q [NLINES];
  logic [NLINES-1:0] blk_vld_q, blk_vld_d;
  logic [LQ-1:0]     wr_onehot, qw_vld_wr;
  logic              wr_same;

  always_comb begin
    wr_onehot          = '0;
    wr_onehot[wr_qsel] = 1'b1;
    wr_same   = blk_vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
    qw_vld_wr = wr_same ? (qw_vld_q[wr_idx] | wr_onehot) : wr_onehot;
    blk_vld_d = blk_vld_q;
    if (wr_en) blk_vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_vld_q <= '0;
    else        blk_vld_q <= blk_vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]    <= wr_tag;
      qw_vld_q[wr_idx] <= qw_vld_wr;
    end
  end

  assign lk_hit = blk_vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag) && qw_vld_q[lk_idx][lk_qsel];

  AST_REFILL_MARKS_QW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> blk_vld_q[$past(wr_idx)] && qw_vld_q[$past(wr_idx)][$past(wr_qsel)]); // R9
  AST_NEWTAG_SINGLE_QW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_same |=> $countones(qw_vld_q[$past(wr_idx)]) == 1); // R9
  AST_SAMETAG_KEEPS_QW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_same |=> (qw_vld_q[$past(wr_idx)] & $past(qw_vld_q[wr_idx])) == $past(qw_vld_q[wr_idx])); // R9
endmodule

// File: rtl/ifetch_datastore.sv
module ifetch_datastore #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned QSEL_W = 2,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [QSEL_W-1:0] wr_qsel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [QSEL_W-1:0] rd_qsel,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned ENTRIES = 1 << (IDX_W + QSEL_W);

  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_idx, wr_qsel}] <= wr_data;
  end

  assign rd_data = mem_q[{rd_idx, rd_qsel}];
endmodule

// File: rtl/ifetch_rotator.sv
module ifetch_rotator
  import ifetch_pkg::*;
#(
  parameter int unsigned OFF_W = 3
) (
  input  logic [(BYTE_W<<OFF_W)-1:0] qw_in,
  input  logic [OFF_W-1:0]           off,
  output logic [(BYTE_W<<OFF_W)-1:0] rot_out,
  output logic [OFF_W:0]             rot_cnt
);
  localparam int unsigned NB = 1 << OFF_W;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [OFF_W:0] src;
    assign src = (OFF_W+1)'(k) + {1'b0, off};
    assign rot_out[k*BYTE_W +: BYTE_W] =
      src[OFF_W] ? '0 : qw_in[{src[OFF_W-1:0], 3'b000} +: BYTE_W];
  end

  assign rot_cnt = (OFF_W+1)'(NB) - {1'b0, off};
endmodule

// File: rtl/ifetch_ibuf.sv
module ifetch_ibuf
  import ifetch_pkg::*;
#(
  parameter int unsigned DEPTH = 25,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned OFF_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [CNT_W-1:0]             cons_req,
  input  logic                         app_offer,
  input  logic [(BYTE_W<<OFF_W)-1:0]   app_bytes,
  input  logic [OFF_W:0]               app_cnt,
  output logic                         app_done,
  output logic [DEPTH*BYTE_W-1:0]      bytes_o,
  output logic [DEPTH-1:0]             valid_o
);
  byte_t            byte_q [DEPTH];
  byte_t            byte_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cons_eff, keep, free_sp, app_ext;

  always_comb begin
    cons_eff = (cons_req > cnt_q) ? cnt_q : cons_req;
    keep     = cnt_q - cons_eff;
    free_sp  = CNT_W'(DEPTH) - keep;
    app_ext  = CNT_W'(app_cnt);
    app_done = app_offer && !flush && (free_sp >= app_ext);
    for (int i = 0; i < DEPTH; i++) begin
      logic [CNT_W:0]   src;
      logic [CNT_W-1:0] aoff;
      src  = (CNT_W+1)'(i) + {1'b0, cons_eff};
      aoff = CNT_W'(i) - keep;
      byte_d[i] = '0;
      if (CNT_W'(i) < keep) begin
        if (src < (CNT_W+1)'(DEPTH)) byte_d[i] = byte_q[src[CNT_W-1:0]];
      end else if (app_done && (aoff < app_ext)) begin
        byte_d[i] = app_bytes[{aoff[OFF_W-1:0], 3'b000} +: BYTE_W];
      end
    end
    if (flush)         cnt_d = '0;
    else if (app_done) cnt_d = keep + app_ext;
    else               cnt_d = keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) byte_q[i] <= byte_d[i];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_out
    assign bytes_o[i*BYTE_W +: BYTE_W] = byte_q[i];
    assign valid_o[i] = (CNT_W'(i) < cnt_q);
  end

  AST_IBUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0); // R8
  AST_CONSUME_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && !app_done && (cons_req >= cnt_q) |=> cnt_q == '0); // R6
  AST_VALID_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_o + DEPTH'(1)) & valid_o) == '0); // R10
endmodule

// File: rtl/ifetch_vcache.sv
module ifetch_vcache
  import ifetch_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned NUM_LINES  = 256,
  parameter int unsigned QW_BYTES   = 8,
  parameter int unsigned IBUF_BYTES = 25,
  parameter logic [31:0] RESET_PC   = 32'h0,
  localparam int unsigned OFF_W     = $clog2(QW_BYTES),
  localparam int unsigned QSEL_W    = $clog2(LINE_BYTES / QW_BYTES),
  localparam int unsigned IDX_W     = $clog2(NUM_LINES),
  localparam int unsigned CNT_W     = $clog2(IBUF_BYTES + 1),
  localparam int unsigned QW_W      = QW_BYTES * BYTE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         redir_valid,
  input  logic [PC_W-1:0]              redir_pc,
  input  logic                         refill_valid,
  input  logic [PC_W-1:OFF_W]          refill_addr,
  input  logic [QW_W-1:0]              refill_data,
  input  logic [CNT_W-1:0]             consume_cnt,
  output logic [IBUF_BYTES*BYTE_W-1:0] ibuf_data,
  output logic [IBUF_BYTES-1:0]        ibuf_valid,
  output logic                         miss_req,
  output logic [PC_W-1:0]              miss_addr
);
  localparam int unsigned QSEL_LSB = OFF_W;
  localparam int unsigned IDX_LSB  = OFF_W + QSEL_W;
  localparam int unsigned TAG_LSB  = IDX_LSB + IDX_W;
  localparam int unsigned TAG_W    = PC_W - TAG_LSB;

  logic [PC_W-1:0] pfpc_q, pfpc_d;
  logic            lk_hit, app_done;
  logic [QW_W-1:0] rd_qw, rot_qw;
  logic [OFF_W:0]  rot_cnt;

  ifetch_tagstore #(.TAG_W(TAG_W), .IDX_W(IDX_W), .QSEL_W(QSEL_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_tag  (pfpc_q[PC_W-1:TAG_LSB]),
    .lk_idx  (pfpc_q[TAG_LSB-1:IDX_LSB]),
    .lk_qsel (pfpc_q[IDX_LSB-1:QSEL_LSB]),
    .wr_en   (refill_valid),
    .wr_tag  (refill_addr[PC_W-1:TAG_LSB]),
    .wr_idx  (refill_addr[TAG_LSB-1:IDX_LSB]),
    .wr_qsel (refill_addr[IDX_LSB-1:QSEL_LSB]),
    .lk_hit  (lk_hit)
  );

  ifetch_datastore #(.IDX_W(IDX_W), .QSEL_W(QSEL_W), .DATA_W(QW_W)) u_data (
    .clk     (clk),
    .wr_en   (refill_valid),
    .wr_idx  (refill_addr[TAG_LSB-1:IDX_LSB]),
    .wr_qsel (refill_addr[IDX_LSB-1:QSEL_LSB]),
    .wr_data (refill_data),
    .rd_idx  (pfpc_q[TAG_LSB-1:IDX_LSB]),
    .rd_qsel (pfpc_q[IDX_LSB-1:QSEL_LSB]),
    .rd_data (rd_qw)
  );

  ifetch_rotator #(.OFF_W(OFF_W)) u_rot (
    .qw_in   (rd_qw),
    .off     (pfpc_q[OFF_W-1:0]),
    .rot_out (rot_qw),
    .rot_cnt (rot_cnt)
  );

  ifetch_ibuf #(.DEPTH(IBUF_BYTES), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_ibuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (redir_valid),
    .cons_req  (consume_cnt),
    .app_offer (lk_hit),
    .app_bytes (rot_qw),
    .app_cnt   (rot_cnt),
    .app_done  (app_done),
    .bytes_o   (ibuf_data),
    .valid_o   (ibuf_valid)
  );

  always_comb begin
    if (redir_valid)   pfpc_d = redir_pc;
    else if (app_done) pfpc_d = {pfpc_q[PC_W-1:OFF_W] + (PC_W-OFF_W)'(1), {OFF_W{1'b0}}};
    else               pfpc_d = pfpc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pfpc_q <= PC_W'(RESET_PC);
    else        pfpc_q <= pfpc_d;
  end

  assign miss_req  = !lk_hit;
  assign miss_addr = {pfpc_q[PC_W-1:OFF_W], {OFF_W{1'b0}}};

  AST_REDIRECT_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> pfpc_q == $past(redir_pc)); // R8
  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid && miss_req |=> $stable(pfpc_q)); // R3
  AST_ADVANCE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid && app_done |=> pfpc_q[OFF_W-1:0] == '0); // R5
  AST_APPEND_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    app_done |-> !miss_req); // R3
endmodule

// File: tb/ifetch_vcache_tb.sv
`timescale 1ns/1ps
module ifetch_vcache_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         redir_valid;
  logic [31:0]  redir_pc;
  logic         refill_valid;
  logic [31:3]  refill_addr;
  logic [63:0]  refill_data;
  logic [4:0]   consume_cnt;
  logic [199:0] ibuf_data;
  logic [24:0]  ibuf_valid;
  logic         miss_req;
  logic [31:0]  miss_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [18:0] mtag [256];
  bit          mbv  [256];
  bit   [3:0]  mqv  [256];
  logic [63:0] mdat [256][4];
  logic [7:0]  mb   [25];
  int          mcnt;
  logic [31:0] mpc;

  always #2 clk = ~clk;

  ifetch_vcache u_dut (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .refill_valid(refill_valid), .refill_addr(refill_addr), .refill_data(refill_data),
    .consume_cnt(consume_cnt), .ibuf_data(ibuf_data), .ibuf_valid(ibuf_valid),
    .miss_req(miss_req), .miss_addr(miss_addr)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(logic [28:0] qa);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = {qa[4:0], 3'(k)};
    return v;
  endfunction

  function automatic bit m_hit(logic [31:0] pc);
    return mbv[pc[12:5]] && (mtag[pc[12:5]] == pc[31:13]) && mqv[pc[12:5]][pc[4:3]];
  endfunction

  task automatic model_step(bit rv, logic [31:0] rpc, bit fv, logic [28:0] fa,
                            logic [63:0] fd, int cons);
    int ce, keep, n;
    bit hit, app;
    ce   = (cons > mcnt) ? mcnt : cons;
    keep = mcnt - ce;
    n    = 8 - int'(mpc[2:0]);
    hit  = m_hit(mpc);
    app  = !rv && hit && ((25 - keep) >= n);
    for (int i = 0; i < keep; i++) mb[i] = mb[i + ce];
    if (app) begin
      for (int k = 0; k < n; k++)
        mb[keep + k] = mdat[mpc[12:5]][mpc[4:3]][8*(int'(mpc[2:0]) + k) +: 8];
      mcnt = keep + n;
      mpc  = {mpc[31:3] + 29'd1, 3'b000};
    end else begin
      mcnt = keep;
    end
    if (rv) begin
      mcnt = 0;
      mpc  = rpc;
    end
    if (fv) begin
      if (mbv[fa[9:2]] && mtag[fa[9:2]] == fa[28:10]) mqv[fa[9:2]][fa[1:0]] = 1'b1;
      else begin
        mtag[fa[9:2]] = fa[28:10];
        mbv[fa[9:2]]  = 1'b1;
        mqv[fa[9:2]]  = 4'b0001 << fa[1:0];
      end
      mdat[fa[9:2]][fa[1:0]] = fd;
    end
  endtask

  task automatic compare(string lbl);
    logic [24:0] expv;
    for (int i = 0; i < 25; i++) expv[i] = (i < mcnt);
    chk("R10", 64'(ibuf_valid), 64'(expv));
    chk("R3", 64'(miss_req), 64'(!m_hit(mpc)));
    chk("R3", 64'(miss_addr), 64'({mpc[31:3], 3'b000}));
    for (int i = 0; i < mcnt; i++) chk(lbl, 64'(ibuf_data[8*i +: 8]), 64'(mb[i]));
  endtask

  task automatic cycle(string lbl, bit rv, logic [31:0] rpc, bit fv, logic [28:0] fa,
                       logic [63:0] fd, int cons);
    @(negedge clk);
    redir_valid  = rv;
    redir_pc     = rpc;
    refill_valid = fv;
    refill_addr  = fa;
    refill_data  = fd;
    consume_cnt  = 5'(cons);
    model_step(rv, rpc, fv, fa, fd, cons);
    @(posedge clk);
    #1;
    compare(lbl);
  endtask

  task automatic idle(string lbl, int cons);
    cycle(lbl, 1'b0, 32'h0, 1'b0, 29'h0, 64'h0, cons);
  endtask

  task automatic redirect(string lbl, logic [31:0] pc);
    cycle(lbl, 1'b1, pc, 1'b0, 29'h0, 64'h0, 0);
  endtask

  task automatic refill(string lbl, logic [28:0] qa);
    cycle(lbl, 1'b0, 32'h0, 1'b1, qa, pat(qa), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    redir_valid = 0; redir_pc = 0; refill_valid = 0; refill_addr = 0;
    refill_data = 0; consume_cnt = 0;
    for (int i = 0; i < 256; i++) begin mbv[i] = 0; mqv[i] = 0; mtag[i] = 0; end
    mcnt = 0; mpc = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 64'(ibuf_valid), 64'h0);
    chk("R1", 64'(miss_req), 64'h1);
    chk("R1", 64'(miss_addr), 64'h0);
    rst_n = 1'b1;

    // R8 and R3: restart at an offset inside an empty line
    redirect("R8", 32'h0000_2003);
    chk("R8", 64'(ibuf_valid), 64'h0);
    chk("R3", 64'(miss_req), 64'h1);
    chk("R3", 64'(miss_addr), 64'h2000);
    // R9: refill makes the quadword hit
    refill("R9", 29'h400);
    chk("R9", 64'(miss_req), 64'h0);
    // R4: bytes 3..7 land at buffer byte 0
    idle("R4", 0);
    chk("R4", 64'(ibuf_data[7:0]), 64'h03);
    chk("R4", 64'($countones(ibuf_valid)), 64'd5);
    // R5 and R2: next quadword of the same line is not valid yet
    chk("R5", 64'(miss_addr), 64'h2008);
    chk("R2", 64'(miss_req), 64'h1);
    // R9: other tag into the same line drops the old quadwords
    refill("R9", 29'h800);
    redirect("R9", 32'h0000_2000);
    chk("R9", 64'(miss_req), 64'h1);
    redirect("R2", 32'h0000_4000);
    chk("R2", 64'(miss_req), 64'h0);
    refill("R9", 29'h401);
    redirect("R9", 32'h0000_4000);
    chk("R9", 64'(miss_req), 64'h1);

    // R7: fill a whole line, stall when full, resume after consume
    for (int q = 0; q < 4; q++) refill("R9", 29'h404 + 29'(q));
    redirect("R8", 32'h0000_2020);
    idle("R4", 0); idle("R4", 0); idle("R4", 0);
    chk("R4", 64'($countones(ibuf_valid)), 64'd24);
    idle("R7", 0);
    chk("R7", 64'($countones(ibuf_valid)), 64'd24);
    chk("R7", 64'(miss_addr), 64'h2038);
    idle("R7", 7);
    chk("R7", 64'($countones(ibuf_valid)), 64'd25);
    chk("R6", 64'(ibuf_data[7:0]), 64'h27);
    chk("R5", 64'(miss_addr), 64'h2040);
    chk("R5", 64'(miss_req), 64'h1);
    idle("R6", 31);
    chk("R6", 64'(ibuf_valid), 64'h0);

    // random mix checked against the model
    for (int n = 0; n < 4000; n++) begin
      bit          rv, fv;
      logic [31:0] pc;
      logic [28:0] qa;
      int          cons;
      pc   = ((32'($urandom_range(1, 2))) << 13) | (32'($urandom_range(0, 3)) << 5)
           | (32'($urandom_range(0, 3)) << 3) | 32'($urandom_range(0, 7));
      qa   = 29'(((32'($urandom_range(1, 2))) << 13 | (32'($urandom_range(0, 3)) << 5)
           | (32'($urandom_range(0, 3)) << 3)) >> 3);
      rv   = ($urandom_range(0, 15) == 0);
      fv   = ($urandom_range(0, 2) == 0);
      cons = $urandom_range(0, 9);
      cycle("R4", rv, pc, fv, qa, {$urandom, $urandom}, cons);
    end

    idle("R6", 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule